// File: doc/BRIEF.md
# Floppy Interface Soft-Switch Bank

This block is the control register bank of a floppy drive interface card sitting in one peripheral slot. The card owns a sixteen-address window on the host bus. The window starts at a bus base address plus sixteen times the slot number, and valid slots are 1 to 7. Every access inside the window flips one control latch, and a read does this just as a write does. The address alone selects the action. Address bit 0 carries the on/off value, and the data written plays no part, except that one address also captures the bus byte for the write shifter.

The latches drive four stepper-motor phase lines, the spindle motor enable and the drive 1/2 select. Power reaches a drive only while the spindle enable is on. Two mode levels, called "mode-A" (`mode_a`) and "mode-B" (`mode_b`), together give the controller's operating mode: read, write-protect sense, shift-out or write-load. On a read access the block returns a byte one cycle later. In sense mode that byte carries the write-protect flag in bit 7. In every other mode it is the byte from the external data shifter. The write-protect flag is raised by the drive's switch and also by phase 1 being energized. The shifter, the sequencer and the drive electronics live outside this block.

Top module: `fdc_soft_switches`

## Requirements
- R1: After reset, all phase lines are off, the spindle is off, drive 1 is selected, both mode levels are low, the mode output reads 0 (read), both one-cycle pulses are low and `bus_rdata` is 0x00.
- R2: An access at window offsets 0x0 to 0x7 sets the phase addressed by offset bits [2:1] to the value of offset bit 0. The other three phases keep their values. The change is visible on the cycle after the access edge.
- R3: Offset 0x8 turns the spindle off and offset 0x9 turns it on.
- R4: Offset 0xA selects drive 1 and offset 0xB selects drive 2. `drv_pwr` bit 0 powers drive 1 and bit 1 powers drive 2. At most one bit is set, and both are 0 while the spindle is off. The selection is kept while the spindle is off.
- R5: Offset 0xC clears mode-A and raises `shift_pulse` for one cycle. Offset 0xD sets mode-A, raises `load_pulse` for one cycle and captures `bus_wdata` into `load_byte`.
- R6: Offset 0xE clears mode-B and offset 0xF sets it. `mode` is {mode-B, mode-A}: 0 = read, 1 = write-protect sense, 2 = shift-out, 3 = write-load.
- R7: A read access and a write access to the same offset have the same effect on the latches.
- R8: An access whose address lies outside this slot's window changes no latch and does not update `bus_rdata`.
- R9: A read access in the window loads `bus_rdata` on its own edge, using the mode as it is after that access. In sense mode the value is {wp_flag, 7'b0}. Otherwise it is `shifter_byte`. A write access leaves `bus_rdata` unchanged.
- R10: The write-protect flag is `wp_switch` OR the phase 1 latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| shifter_byte | input | 8 | Byte held by the external data shifter |
| wp_switch | input | 1 | Drive write-protect switch, 1 = protected |
| phase | output | NPH | Stepper phase drive lines |
| motor_on | output | 1 | Spindle enable |
| drv_pwr | output | 2 | Power routing to drive 1 (bit 0) and drive 2 (bit 1) |
| mode_a | output | 1 | Mode level A |
| mode_b | output | 1 | Mode level B |
| mode | output | 2 | Decoded controller mode |
| shift_pulse | output | 1 | One-cycle shift request |
| load_pulse | output | 1 | One-cycle load request |
| load_byte | output | 8 | Byte captured for writing |

## Verification
The hardest case to reach is a write-protect flag raised by phase 1 instead of by the switch. Getting there needs three steps with `wp_switch` held low: mode-B cleared, phase 1 energized, and then a read of the mode-A-set offset so that the sense byte is returned. The stimulus does exactly that, then turns phase 1 off again and expects bit 7 to drop.

A second case is the drive select made while the spindle is off. The stimulus picks a drive with the spindle off and checks that no power is routed. It then turns the spindle on, off and on again around a second select, to show that the selection is kept.

// File: rtl/fdc_sw_pkg.sv
package fdc_sw_pkg;

  localparam int NPH = 4;

  typedef enum logic [1:0] {
    MODE_READ  = 2'b00,
    MODE_SENSE = 2'b01,
    MODE_SHIFT = 2'b10,
    MODE_LOAD  = 2'b11
  } ctl_mode_e;

  // One decoded switch action; at most one *_en field is set per cycle.
  typedef struct packed {
    logic           hit;
    logic [NPH-1:0] ph_en;
    logic           ph_val;
    logic           mot_en;
    logic           mot_val;
    logic           drv_en;
    logic           drv_val;   // 0 = drive 1, 1 = drive 2
    logic           ma_en;
    logic           ma_val;
    logic           mb_en;
    logic           mb_val;
  } sw_act_t;

endpackage

// File: rtl/fdc_sw_decode.sv
module fdc_sw_decode
  import fdc_sw_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC080,
  parameter int                SLOT     = 6
) (
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  output sw_act_t           act
);

  localparam bit                SLOT_OK   = (SLOT >= 1) && (SLOT <= 7);
  localparam logic [ADDR_W-1:0] WIN_START = ADDR_W'(WIN_BASE + SLOT * 16);

  logic       in_win;
  logic [3:0] off;

  assign in_win = bus_sel && SLOT_OK &&
                  (bus_addr[ADDR_W-1:4] == WIN_START[ADDR_W-1:4]);
  assign off    = bus_addr[3:0];

  always_comb begin
    act     = '0;
    act.hit = in_win;
    if (in_win) begin
      if (!off[3]) begin
        act.ph_en[off[2:1]] = 1'b1;
        act.ph_val          = off[0];
      end else begin
        unique case (off[2:1])
          2'b00: begin act.mot_en = 1'b1; act.mot_val = off[0]; end
          2'b01: begin act.drv_en = 1'b1; act.drv_val = off[0]; end
          2'b10: begin act.ma_en  = 1'b1; act.ma_val  = off[0]; end
          default: begin act.mb_en = 1'b1; act.mb_val = off[0]; end
        endcase
      end
    end
  end

endmodule

// File: rtl/fdc_sw_phases.sv
module fdc_sw_phases
  import fdc_sw_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  sw_act_t        act,
  output logic [NPH-1:0] phase_q,
  output logic [NPH-1:0] phase_d
);

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    always_comb begin
      phase_d[i] = phase_q[i];
      if (act.ph_en[i]) phase_d[i] = act.ph_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              phase_q[i] <= 1'b0;
      else if (act.ph_en[i])   phase_q[i] <= phase_d[i];
    end
  end

endmodule

// File: rtl/fdc_sw_ctl.sv
module fdc_sw_ctl
  import fdc_sw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sw_act_t    act,
  input  logic [7:0] bus_wdata,
  output logic       motor_q,
  output logic [1:0] drv_pwr,
  output logic       ma_q,
  output logic       mb_q,
  output logic       ma_d,
  output logic       mb_d,
  output logic       shift_q,
  output logic       load_q,
  output logic [7:0] load_byte_q
);

  logic motor_d, drv2_q, drv2_d;
  logic shift_d, load_d;

  always_comb begin
    motor_d = act.mot_en ? act.mot_val : motor_q;
    drv2_d  = act.drv_en ? act.drv_val : drv2_q;
    ma_d    = act.ma_en  ? act.ma_val  : ma_q;
    mb_d    = act.mb_en  ? act.mb_val  : mb_q;
    shift_d = act.ma_en && !act.ma_val;
    load_d  = act.ma_en &&  act.ma_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      motor_q <= 1'b0;
      drv2_q  <= 1'b0;
      ma_q    <= 1'b0;
      mb_q    <= 1'b0;
    end else if (act.hit) begin
      motor_q <= motor_d;
      drv2_q  <= drv2_d;
      ma_q    <= ma_d;
      mb_q    <= mb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      load_q  <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      load_byte_q <= 8'h00;
    else if (load_d) load_byte_q <= bus_wdata;
  end

  assign drv_pwr = motor_q ? (drv2_q ? 2'b10 : 2'b01) : 2'b00;

endmodule

// File: rtl/fdc_sw_readback.sv
module fdc_sw_readback
  import fdc_sw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       ma_d,
  input  logic       mb_d,
  input  logic       ph1_d,
  input  logic       wp_switch,
  input  logic [7:0] shifter_byte,
  output logic [7:0] rdata_q
);

  logic [7:0] rdata_d;
  logic       sense;

  always_comb begin
    sense   = (ctl_mode_e'({mb_d, ma_d}) == MODE_SENSE);
    rdata_d = sense ? {(wp_switch | ph1_d), 7'b0} : shifter_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= 8'h00;
    else if (rd_en) rdata_q <= rdata_d;
  end

endmodule

// File: rtl/fdc_soft_switches.sv
module fdc_soft_switches
  import fdc_sw_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC080,
  parameter int                SLOT     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        shifter_byte,
  input  logic              wp_switch,
  output logic [NPH-1:0]    phase,
  output logic              motor_on,
  output logic [1:0]        drv_pwr,
  output logic              mode_a,
  output logic              mode_b,
  output logic [1:0]        mode,
  output logic              shift_pulse,
  output logic              load_pulse,
  output logic [7:0]        load_byte
);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  sw_act_t        act;
  logic [NPH-1:0] phase_d;
  logic           ma_d, mb_d;

  fdc_sw_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .SLOT(SLOT)) u_decode (
    .bus_sel  (bus_sel),
    .bus_addr (bus_addr),
    .act      (act)
  );

  fdc_sw_phases u_phases (
    .clk     (clk),
    .rst_n   (rst_sync),
    .act     (act),
    .phase_q (phase),
    .phase_d (phase_d)
  );

  fdc_sw_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_sync),
    .act         (act),
    .bus_wdata   (bus_wdata),
    .motor_q     (motor_on),
    .drv_pwr     (drv_pwr),
    .ma_q        (mode_a),
    .mb_q        (mode_b),
    .ma_d        (ma_d),
    .mb_d        (mb_d),
    .shift_q     (shift_pulse),
    .load_q      (load_pulse),
    .load_byte_q (load_byte)
  );

  fdc_sw_readback u_readback (
    .clk          (clk),
    .rst_n        (rst_sync),
    .rd_en        (act.hit && !bus_we),
    .ma_d         (ma_d),
    .mb_d         (mb_d),
    .ph1_d        (phase_d[1]),
    .wp_switch    (wp_switch),
    .shifter_byte (shifter_byte),
    .rdata_q      (bus_rdata)
  );

  assign mode = {mode_b, mode_a};

endmodule

// File: rtl/fdc_soft_switches_chk.sv
module fdc_soft_switches_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC080,
  parameter int                SLOT     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        phase,
  input logic              motor_on,
  input logic [1:0]        drv_pwr,
  input logic              mode_a,
  input logic              mode_b,
  input logic              shift_pulse,
  input logic              load_pulse
);

  localparam logic [ADDR_W-1:0] WIN_START = ADDR_W'(WIN_BASE + SLOT * 16);

  logic in_win;
  assign in_win = bus_sel && (bus_addr[ADDR_W-1:4] == WIN_START[ADDR_W-1:4]);

  assert_pwr_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_pwr));

  assert_pwr_needs_motor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|drv_pwr) |-> motor_on);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |=> ($stable(phase) && $stable(motor_on) && $stable(mode_a) && $stable(mode_b)));

  assert_motor_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motor_on) |-> $past(in_win && bus_addr[3:0] == 4'h9));

  assert_shift_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |-> !mode_a);

  assert_load_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> mode_a);

  assert_modeb_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_b) |-> $past(in_win && bus_addr[3:0] == 4'hF));

endmodule

bind fdc_soft_switches fdc_soft_switches_chk #(
  .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .SLOT(SLOT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_addr    (bus_addr),
  .phase       (phase),
  .motor_on    (motor_on),
  .drv_pwr     (drv_pwr),
  .mode_a      (mode_a),
  .mode_b      (mode_b),
  .shift_pulse (shift_pulse),
  .load_pulse  (load_pulse)
);

// File: tb/fdc_soft_switches_bench.sv
module fdc_soft_switches_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, shifter_byte, load_byte;
  logic        wp_switch;
  logic [3:0]  phase;
  logic        motor_on, mode_a, mode_b, shift_pulse, load_pulse;
  logic [1:0]  drv_pwr, mode;

  int nchk  = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  fdc_soft_switches u_fdc_soft_switches (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .shifter_byte(shifter_byte), .wp_switch(wp_switch), .phase(phase),
    .motor_on(motor_on), .drv_pwr(drv_pwr), .mode_a(mode_a), .mode_b(mode_b),
    .mode(mode), .shift_pulse(shift_pulse), .load_pulse(load_pulse),
    .load_byte(load_byte)
  );

  // Slot 6 window: 0xC0E0..0xC0EF
  localparam logic [15:0] WIN = 16'hC0E0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // One-cycle access; returns at the negedge after the access edge.
  task automatic access(input logic [15:0] a, input logic we, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 phase", {4'b0, phase}, 8'h00);
    chk("R1 motor", {7'b0, motor_on}, 8'h00);
    chk("R1 drv_pwr", {6'b0, drv_pwr}, 8'h00);
    chk("R1 mode", {6'b0, mode}, 8'h00);
    chk("R1 pulses", {6'b0, shift_pulse, load_pulse}, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
  endtask

  task automatic t_phase;
    access(WIN | 16'h1, 1'b1, 8'hFF);
    chk("R2 ph0 on", {4'b0, phase}, 8'h01);
    access(WIN | 16'h5, 1'b0, 8'h00);
    chk("R2 R7 ph2 on by read", {4'b0, phase}, 8'h05);
    access(WIN | 16'h7, 1'b1, 8'h00);
    chk("R2 ph3 on", {4'b0, phase}, 8'h0D);
    access(WIN | 16'h0, 1'b0, 8'h00);
    chk("R2 ph0 off", {4'b0, phase}, 8'h0C);
    access(WIN | 16'h4, 1'b1, 8'h00);
    access(WIN | 16'h6, 1'b1, 8'h00);
    chk("R2 all off", {4'b0, phase}, 8'h00);
  endtask

  task automatic t_motor_drive;
    access(WIN | 16'hB, 1'b1, 8'h00);
    chk("R4 no power while spindle off", {6'b0, drv_pwr}, 8'h00);
    access(WIN | 16'h9, 1'b0, 8'h00);
    chk("R3 motor on", {7'b0, motor_on}, 8'h01);
    chk("R4 drive2 powered", {6'b0, drv_pwr}, 8'h02);
    access(WIN | 16'hA, 1'b1, 8'h00);
    chk("R4 drive1 powered", {6'b0, drv_pwr}, 8'h01);
    access(WIN | 16'h8, 1'b1, 8'h00);
    chk("R3 motor off", {7'b0, motor_on}, 8'h00);
    chk("R4 power off", {6'b0, drv_pwr}, 8'h00);
    access(WIN | 16'h9, 1'b1, 8'h00);
    chk("R4 selection kept", {6'b0, drv_pwr}, 8'h01);
  endtask

  task automatic t_modes;
    access(WIN | 16'hD, 1'b1, 8'h5A);
    chk("R5 load pulse", {7'b0, load_pulse}, 8'h01);
    chk("R5 load byte", load_byte, 8'h5A);
    chk("R6 sense mode", {6'b0, mode}, 8'h01);
    @(negedge clk);
    chk("R5 load pulse one cycle", {7'b0, load_pulse}, 8'h00);
    access(WIN | 16'hF, 1'b0, 8'h00);
    chk("R6 load mode", {6'b0, mode}, 8'h03);
    access(WIN | 16'hC, 1'b1, 8'h00);
    chk("R5 shift pulse", {7'b0, shift_pulse}, 8'h01);
    chk("R6 shift-out mode", {6'b0, mode}, 8'h02);
    access(WIN | 16'hE, 1'b1, 8'h00);
    chk("R6 read mode", {6'b0, mode}, 8'h00);
    chk("R5 shift pulse one cycle", {7'b0, shift_pulse}, 8'h00);
  endtask

  task automatic t_readback;
    shifter_byte = 8'h3C;
    wp_switch = 1'b0;
    access(WIN | 16'hC, 1'b0, 8'h00);
    chk("R9 shifter byte in read mode", bus_rdata, 8'h3C);
    wp_switch = 1'b1;
    access(WIN | 16'hD, 1'b0, 8'h00);
    chk("R9 sense byte protected", bus_rdata, 8'h80);
    wp_switch = 1'b0;
    access(WIN | 16'hD, 1'b0, 8'h00);
    chk("R9 sense byte clear", bus_rdata, 8'h00);
    wp_switch = 1'b1;
    access(WIN | 16'hD, 1'b1, 8'h11);
    chk("R9 write leaves rdata", bus_rdata, 8'h00);
    access(WIN | 16'hF, 1'b0, 8'h00);
    chk("R9 load mode returns shifter", bus_rdata, 8'h3C);
    wp_switch = 1'b0;
  endtask

  task automatic t_wp_phase1;
    access(WIN | 16'hE, 1'b1, 8'h00);
    access(WIN | 16'h3, 1'b1, 8'h00);
    access(WIN | 16'hD, 1'b0, 8'h00);
    chk("R10 phase1 raises protect", bus_rdata, 8'h80);
    access(WIN | 16'h2, 1'b1, 8'h00);
    access(WIN | 16'hD, 1'b0, 8'h00);
    chk("R10 phase1 off clears protect", bus_rdata, 8'h00);
  endtask

  task automatic t_other_slot;
    shifter_byte = 8'hA5;
    access(16'hC0D8, 1'b1, 8'h00);
    chk("R8 motor kept", {7'b0, motor_on}, 8'h01);
    access(16'hC0D3, 1'b0, 8'h00);
    chk("R8 phase kept", {4'b0, phase}, 8'h00);
    access(16'hC0FF, 1'b1, 8'h00);
    chk("R8 mode kept", {6'b0, mode}, 8'h01);
    access(16'hC0DC, 1'b0, 8'h00);
    chk("R8 rdata kept", bus_rdata, 8'h00);
  endtask

  initial begin
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    shifter_byte = 8'h00; wp_switch = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_phase();
    t_motor_drive();
    t_modes();
    t_readback();
    t_wp_phase1();
    t_other_slot();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule